// File: doc/BRIEF.md
# Variable-Length Instruction Stream Framer

This block sits between instruction fetch and decode. Fetch delivers a stream of 16-bit halfwords. The block regroups that stream into whole instructions of either 16 or 32 bits. Short and long instructions may be mixed in any order.

The length of an instruction is decided from its leading halfword alone. The block compares that halfword against a small set of masked opcode patterns. When a leading halfword marks a long instruction, the block keeps it in a holding register until the trailing halfword arrives. It then emits both halfwords together as one word. The trailing halfword is never sized, so its bit pattern has no effect on framing.

Both sides use valid/ready. An input halfword transfers on a clock edge where `in_valid` and `in_ready` are both high. An output instruction transfers on a clock edge where `out_valid` and `out_ready` are both high. Once `out_valid` is raised, it stays high and `out_word`/`out_long` stay unchanged until the instruction is taken. While an instruction is waiting and `out_ready` is low, `in_ready` is low. When the waiting instruction is taken, a new halfword may be accepted on the same edge, so the stream runs at one halfword per cycle under full readiness. The `flush` input, used on a branch redirect, discards any held leading halfword and any waiting instruction.

Top module: `hw_stream_framer`

## Requirements
- R1: A leading halfword `h` with `(h & 16'hF00F)` equal to `16'h0000`, `16'h0001` or `16'h3001` starts a 32-bit instruction.
- R2: A leading halfword `h` with `(h & 16'hF08F) == 16'h3009` starts a 32-bit instruction. A halfword that matches this except that bit 7 is set (for example `16'h3089`) is short.
- R3: Any leading halfword that matches none of the R1/R2 patterns is emitted on its own: `out_word = {16'h0000, h}` and `out_long = 0`.
- R4: A 32-bit instruction is emitted with the leading halfword in `out_word[31:16]`, the trailing halfword in `out_word[15:0]`, and `out_long = 1`. The trailing halfword is never sized: one that would itself match R1 still only completes the instruction.
- R5: While a leading halfword of a long instruction is held, `out_valid` stays low.
- R6: While `out_valid` is high and `out_ready` is low, `out_word`, `out_long` and `out_valid` hold their values and `in_ready` is low.
- R7: When `flush` is high on a clock edge, the held leading halfword and any waiting output are discarded, and `out_valid` is low after that edge. The next accepted halfword is sized as the start of a new instruction.
- R8: Reset is synchronous and active-high. After reset, `out_valid` is low, `in_ready` is high, and no leading halfword is held.
- R9: `in_ready` is low in any cycle where `flush` is high.
- R10: A short instruction accepted on an edge is presented with `out_valid` high directly after that edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard held and waiting state (branch redirect) |
| in_valid | input | 1 | Input halfword valid |
| in_ready | output | 1 | Block can accept a halfword |
| in_half | input | 16 | Input halfword |
| out_valid | output | 1 | Output instruction valid |
| out_ready | input | 1 | Consumer takes the instruction |
| out_word | output | 32 | Framed instruction, upper half zero when short |
| out_long | output | 1 | 1 for a 32-bit instruction |

## Verification
A wrong framing state shows at the ports on the very next output. If the block wrongly believes a leading halfword is held, the following short instruction comes out merged with stale upper bits and `out_long` set. If it loses a held leading halfword, the trailing halfword comes out as a short instruction of its own, and every later boundary is shifted. Back-pressure faults appear within one cycle, as a changed `out_word` or a raised `in_ready` while an instruction is waiting. Flush faults appear as a stale instruction or a merged word on the first halfword after the redirect.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

  localparam int HALF_W  = 16;
  localparam int WORD_W  = 2 * HALF_W;
  localparam int NUM_PAT = 4;

  typedef struct packed {
    logic [HALF_W-1:0] mask;
    logic [HALF_W-1:0] match;
  } pat_t;

  // Masked opcode patterns that mark a leading halfword of a long instruction.
  function automatic pat_t pat_at(input int idx);
    pat_t p;
    case (idx)
      0:       p = '{mask: 16'hF00F, match: 16'h0000};  // 20-bit immediate move
      1:       p = '{mask: 16'hF00F, match: 16'h0001};  // 20-bit immediate move, shifted
      2:       p = '{mask: 16'hF00F, match: 16'h3001};  // extended (float) move forms
      default: p = '{mask: 16'hF08F, match: 16'h3009};  // bit-operation forms, bit 7 clear
    endcase
    return p;
  endfunction

  function automatic logic head_is_long(input logic [HALF_W-1:0] h);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_PAT; i++) begin
      if ((h & pat_at(i).mask) == pat_at(i).match) r = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hsf_len_decode.sv
module hsf_len_decode
  import hsf_pkg::*;
#(
  parameter int HW = HALF_W,
  parameter int NP = NUM_PAT
) (
  input  logic [HW-1:0] half,
  output logic [NP-1:0] hits,
  output logic          is_long
);

  for (genvar gi = 0; gi < NP; gi++) begin : g_pat
    localparam pat_t P = pat_at(gi);
    assign hits[gi] = ((half & P.mask) == P.match);
  end

  assign is_long = |hits;

  // The patterns are disjoint, so at most one may hit.
  always_comb begin
    if (!$isunknown(half)) begin
      AST_PATTERN_EXCLUSIVE: assert ($onehot0(hits)); // R1
    end
  end

endmodule

// File: rtl/hsf_assembler.sv
module hsf_assembler
  import hsf_pkg::*;
#(
  parameter int HW = HALF_W,
  localparam int WW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          in_fire,
  input  logic [HW-1:0] in_half,
  input  logic          head_long,
  output logic          holding,
  output logic          emit_valid,
  output logic [WW-1:0] emit_word,
  output logic          emit_long
);

  typedef enum logic {ST_HEAD, ST_TAIL} asm_state_t;

  asm_state_t        state_q;
  logic [HW-1:0]     head_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state_q <= ST_HEAD;
    end else if (in_fire) begin
      if (state_q == ST_TAIL) begin
        state_q <= ST_HEAD;
      end else if (head_long) begin
        state_q <= ST_TAIL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
    end else if (in_fire && state_q == ST_HEAD && head_long) begin
      head_q <= in_half;
    end
  end

  always_comb begin
    emit_valid = 1'b0;
    emit_word  = '0;
    emit_long  = 1'b0;
    if (in_fire) begin
      if (state_q == ST_TAIL) begin
        emit_valid = 1'b1;
        emit_word  = {head_q, in_half};
        emit_long  = 1'b1;
      end else if (!head_long) begin
        emit_valid = 1'b1;
        emit_word  = {{HW{1'b0}}, in_half};
      end
    end
  end

  assign holding = (state_q == ST_TAIL);

  AST_FLUSH_DROPS_HEAD: assert property (@(posedge clk) disable iff (rst)
    flush |=> !holding); // R7

  AST_TAIL_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    (holding && in_fire && !flush) |=> !holding); // R4

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
    (!holding && in_fire && head_long && !flush) |=> (holding && head_q == $past(in_half))); // R5

endmodule

// File: rtl/hsf_out_stage.sv
module hsf_out_stage
  import hsf_pkg::*;
#(
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          load,
  input  logic [WW-1:0] load_word,
  input  logic          load_long,
  input  logic          out_ready,
  output logic          can_load,
  output logic          out_valid,
  output logic [WW-1:0] out_word,
  output logic          out_long
);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word <= '0;
      out_long <= 1'b0;
    end else if (load && !flush) begin
      out_word <= load_word;
      out_long <= load_long;
    end
  end

  assign can_load = !out_valid || out_ready;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_word) && $stable(out_long))); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid); // R7

endmodule

// File: rtl/hw_stream_framer.sv
module hw_stream_framer
  import hsf_pkg::*;
#(
  parameter int HW = HALF_W,
  localparam int WW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [HW-1:0] in_half,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [WW-1:0] out_word,
  output logic          out_long
);

  logic [NUM_PAT-1:0] pat_hits;
  logic               head_long;
  logic               can_load;
  logic               in_fire;
  logic               holding;
  logic               emit_valid;
  logic [WW-1:0]      emit_word;
  logic               emit_long;

  assign in_ready = can_load && !flush;
  assign in_fire  = in_valid && in_ready;

  hsf_len_decode #(.HW(HW), .NP(NUM_PAT)) u_decode (
    .half    (in_half),
    .hits    (pat_hits),
    .is_long (head_long)
  );

  hsf_assembler #(.HW(HW)) u_asm (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .in_fire    (in_fire),
    .in_half    (in_half),
    .head_long  (head_long),
    .holding    (holding),
    .emit_valid (emit_valid),
    .emit_word  (emit_word),
    .emit_long  (emit_long)
  );

  hsf_out_stage #(.WW(WW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .load      (emit_valid),
    .load_word (emit_word),
    .load_long (emit_long),
    .out_ready (out_ready),
    .can_load  (can_load),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_long  (out_long)
  );

  AST_NO_ACCEPT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R6

  AST_FLUSH_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_ready); // R9

  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_long) |-> (out_word[WW-1:HW] == '0)); // R3

  AST_LONG_HEAD_MATCH: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_long) |-> head_is_long(out_word[WW-1:HW])); // R4

  AST_SHORT_NOT_LONG_HEAD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_long) |-> !head_is_long(out_word[HW-1:0])); // R2

  AST_SHORT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_fire && !holding && !head_long && !flush) |=> out_valid); // R10

endmodule

// File: tb/hw_stream_framer_bench.sv
module hw_stream_framer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_half = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_long;

  int checks = 0;
  int fails  = 0;
  logic [32:0] mon_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_stream_framer u_hw_stream_framer (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_half   (in_half),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_long  (out_long)
  );

  // Records each output transfer a quarter cycle before the edge it occurs on.
  always begin
    @(negedge clk);
    #(Q);
    if (!rst && out_valid && out_ready) mon_q.push_back({out_long, out_word});
  end

  task automatic check(input string req, input string what, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_half(input logic [15:0] h);
    @(negedge clk);
    in_valid = 1'b1;
    in_half  = h;
    forever begin
      #(Q);
      if (in_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [31:0] w, input logic l);
    int waited = 0;
    while (mon_q.size() == 0 && waited < 20) begin
      @(negedge clk);
      #(Q + 1);
      waited++;
    end
    if (mon_q.size() == 0) begin
      check(req, "no output", 33'h0, {l, w});
    end else begin
      check(req, "output word/long", mon_q.pop_front(), {l, w});
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    flush = 1'b0;
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mon_q.delete();
  endtask

  task automatic t_reset_state();
    do_reset();
    #(Q);
    check("R8", "out_valid after reset", {32'h0, out_valid}, 33'h0);
    check("R8", "in_ready after reset", {32'h0, in_ready}, 33'h1);
  endtask

  task automatic t_short_stream();
    send_half(16'h1234);
    #1;
    check("R10", "out_valid one cycle after accept", {32'h0, out_valid}, 33'h1);
    expect_out("R3", 32'h0000_1234, 1'b0);
    send_half(16'h3089);
    expect_out("R2", 32'h0000_3089, 1'b0);
    send_half(16'hFFFF);
    expect_out("R3", 32'h0000_FFFF, 1'b0);
    send_half(16'h300A);
    expect_out("R3", 32'h0000_300A, 1'b0);
    send_half(16'h0A52);
    expect_out("R3", 32'h0000_0A52, 1'b0);
  endtask

  task automatic t_long_forms();
    send_half(16'h0A50); send_half(16'hBEEF);
    expect_out("R1", 32'h0A50_BEEF, 1'b1);
    send_half(16'h0A51); send_half(16'h1111);
    expect_out("R1", 32'h0A51_1111, 1'b1);
    send_half(16'h3451); send_half(16'hCAFE);
    expect_out("R1", 32'h3451_CAFE, 1'b1);
    send_half(16'h3079); send_half(16'h5A5A);
    expect_out("R2", 32'h3079_5A5A, 1'b1);
    // Trailing halfword that would itself be a long head.
    send_half(16'h0C01); send_half(16'h0000);
    send_half(16'h7777);
    expect_out("R4", 32'h0C01_0000, 1'b1);
    expect_out("R4", 32'h0000_7777, 1'b0);
  endtask

  task automatic t_partial_silent();
    send_half(16'h3B59);
    repeat (3) begin
      #(Q);
      check("R5", "out_valid while head held", {32'h0, out_valid}, 33'h0);
      @(negedge clk);
    end
    send_half(16'h4321);
    expect_out("R5", 32'h3B59_4321, 1'b1);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    send_half(16'h1357);
    held = out_word;
    check("R6", "held word", {1'b0, held}, {1'b0, 32'h0000_1357});
    @(negedge clk);
    in_valid = 1'b1;
    in_half  = 16'h2468;
    repeat (3) begin
      #(Q);
      check("R6", "in_ready while blocked", {32'h0, in_ready}, 33'h0);
      check("R6", "stable word", {out_long, out_word}, {1'b0, held});
      check("R6", "valid held", {32'h0, out_valid}, 33'h1);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R6", 32'h0000_1357, 1'b0);
    expect_out("R6", 32'h0000_2468, 1'b0);
  endtask

  task automatic t_flush();
    send_half(16'h0A50);
    @(negedge clk);
    flush = 1'b1;
    #(Q);
    check("R9", "in_ready during flush", {32'h0, in_ready}, 33'h0);
    @(negedge clk);
    flush = 1'b0;
    send_half(16'h2222);
    expect_out("R7", 32'h0000_2222, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    send_half(16'h4444);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    #(Q);
    check("R7", "out_valid after flush", {32'h0, out_valid}, 33'h0);
    @(negedge clk);
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    check("R7", "flushed word not delivered", {1'b0, 32'(mon_q.size())}, 33'h0);
  endtask

  task automatic t_reset_mid();
    send_half(16'h3001);
    do_reset();
    send_half(16'h5555);
    expect_out("R8", 32'h0000_5555, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_short_stream();
    t_long_forms();
    t_partial_silent();
    t_backpressure();
    t_flush();
    t_reset_mid();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule